// File: doc/BRIEF.md
# Cascadable 8/16-bit Up Timer

This block is an up-counting timer built from two byte-wide counters. The low byte always counts. A run-time enable input makes the high byte join the low byte as its most significant half, which turns the pair into one 16-bit counter. When that input is low, the high byte stays frozen and the low byte runs on its own as an 8-bit counter.

Software preloads either byte through a write strobe and a shared data bus. The current value of both bytes is always visible on output ports. A rate input sets how often the counter advances: on every system clock, or on every second system clock. When the active counter wraps from its all-ones value to zero, the block raises a one-clock overflow pulse. Software sets the period by loading a start value, since the number of count steps to overflow is the distance from that value to the wrap point.

Top module: `casc_timer`

## Requirements
- R1: With `rst_n` low at a clock edge, `lo_q`, `hi_q` and `ovf` are all 0 after that edge, and the half-rate phase is cleared.
- R2: A `wr_lo` pulse loads `wr_data` into `lo_q`, visible after the next clock edge. No count step is applied to either byte in that cycle.
- R3: A `wr_hi` pulse loads `wr_data` into `hi_q`, visible after the next clock edge. No count step is applied to either byte in that cycle.
- R4: With `half_rate` = 0, a count step happens on every clock that has no write.
- R5: With `half_rate` = 1, count steps happen on alternate clocks. The first step comes on the second clock after the rate is selected, and the alternation continues through write cycles.
- R6: With `hi_en` = 0, `hi_q` keeps its value except through `wr_hi`, and `ovf` follows a low-byte step from 0xFF to 0x00.
- R7: With `hi_en` = 1, a low-byte step from 0xFF also increments `hi_q`. `ovf` follows only when both bytes step from 0xFF to 0x00 together.
- R8: `ovf` is high for exactly one clock, and it is high in the same cycle that the wrapped value 0 first shows on the counter outputs.
- R9: At full rate, loading low value L gives `ovf` 256−L clocks after the load becomes visible in 8-bit mode. With high value H loaded as well, the gap is 65536−(H·256+L) clocks in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_en | input | 1 | 1: high byte joins the count (16-bit mode) |
| half_rate | input | 1 | 1: one count step every second clock |
| wr_lo | input | 1 | Load strobe for the low byte |
| wr_hi | input | 1 | Load strobe for the high byte |
| wr_data | input | 8 | Value to load |
| lo_q | output | 8 | Current low byte |
| hi_q | output | 8 | Current high byte |
| ovf | output | 1 | One-clock overflow pulse |

## Verification
The bench builds the block with its default byte width of 8, so that the wrap points in both modes fall at 256 and 65536 steps. These are short enough to reach from loaded values near the top of the range. Preloading values such as 0xF0, or 0xFF in the high byte, reaches the carry from low into high byte, the double wrap in 16-bit mode and the frozen high byte in 8-bit mode within a few hundred clocks. A behavioural model compares all three outputs on every clock under both rates and with writes landing on step and non-step phases.

// File: rtl/timer_pkg.sv
// Shared constants for the cascadable timer.
// Assumes: both counter halves share one byte width.
package timer_pkg;
    parameter int unsigned BYTE_W = 8;
endpackage

// File: rtl/tmr_step_gen.sv
// Count-step generator: produces a step strobe every clock (full rate) or
// every second clock (half rate). The phase register is cleared while full
// rate is selected, so the first half-rate step lands on the second clock.
// Assumes: synchronous active-low reset.
module tmr_step_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    output logic step
);
    logic phase_q;

    // Toggle the phase while in half-rate mode, park it at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= 1'b0;
        else if (half_rate) phase_q <= ~phase_q;
        else                phase_q <= 1'b0;
    end

    // A step is issued on every clock at full rate, on odd phases at half rate.
    always_comb step = ~half_rate | phase_q;

    // R5: two consecutive half-rate clocks never both step.
    a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && step) |=> (!step || !half_rate));
    // R4: full rate always steps.
    a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        !half_rate |-> step);
endmodule

// File: rtl/tmr_byte_cnt.sv
// One counter byte with a synchronous load and an increment strobe.
// Load has priority over increment. Flags the all-ones value for carry.
// Assumes: caller never asserts ld and inc expecting both to apply.
module tmr_byte_cnt #(
    parameter int unsigned W = timer_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         at_max
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    // Hold, load or increment the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + 1'b1;
    end

    // Carry-out condition for the next byte and the overflow detector.
    always_comb at_max = (q == ALL_ONES);

    // R2/R3: a load shows the loaded value after the edge.
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(ld_val));
    // R4: an increment without load advances by one, modulo 2^W.
    a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> q == W'($past(q) + 1'b1));
endmodule

// File: rtl/casc_timer.sv
// Cascadable 8/16-bit up timer. The low byte counts on every step that has
// no software write; the high byte counts on low-byte carry when enabled.
// The overflow pulse is registered so it coincides with the wrapped zero.
// Assumes: a write to either byte suppresses the count step in that cycle.
module casc_timer #(
    parameter int unsigned W = timer_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hi_en,
    input  logic         half_rate,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic         ovf
);
    localparam int unsigned NBYTES = 2;

    logic              step;
    logic              count_en;
    logic [NBYTES-1:0] ld_v;
    logic [NBYTES-1:0] inc_v;
    logic [NBYTES-1:0] max_v;
    logic [W-1:0]      q_v [NBYTES];
    logic              wrap_now;

    tmr_step_gen u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_rate (half_rate),
        .step      (step)
    );

    // A count step applies only when no byte is being written.
    always_comb count_en = step & ~wr_lo & ~wr_hi;

    // Per-byte load and increment strobes.
    always_comb begin
        ld_v[0]  = wr_lo;
        ld_v[1]  = wr_hi;
        inc_v[0] = count_en;
        inc_v[1] = count_en & hi_en & max_v[0];
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        tmr_byte_cnt #(.W(W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_v[b]),
            .ld_val (wr_data),
            .inc    (inc_v[b]),
            .q      (q_v[b]),
            .at_max (max_v[b])
        );
    end

    always_comb begin
        lo_q = q_v[0];
        hi_q = q_v[1];
    end

    // The active counter wraps on this step.
    always_comb wrap_now = count_en & max_v[0] & (~hi_en | max_v[1]);

    // Register the overflow pulse so it lines up with the zero value.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= wrap_now;
    end

    // R1: reset clears both bytes and the pulse.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (lo_q == '0 && hi_q == '0 && !ovf));
    // R8: the pulse never lasts two clocks.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);
    // R8: the pulse comes with the wrapped low byte.
    a_r8_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> lo_q == '0);
    // R7: in 16-bit mode the high byte is zero with the pulse.
    a_r7_hi_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && $past(hi_en)) |-> hi_q == '0);
    // R6: a disabled high byte only changes by write.
    a_r6_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_en && !wr_hi) |=> $stable(hi_q));
endmodule

// File: tb/casc_timer_bench.sv
module casc_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_en = 1'b0;
    logic       half_rate = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] lo_q, hi_q;
    logic       ovf;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    int cycles = 0;

    // behavioural reference state
    int m_lo = 0, m_hi = 0, m_ph = 0, m_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_timer u_casc_timer (
        .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .half_rate(half_rate),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .lo_q(lo_q), .hi_q(hi_q), .ovf(ovf)
    );

    task automatic chk(string req, int act, int exp_v);
        vectors++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp_v);
        end
    endtask

    // reference model update from the requirements (R1..R7)
    always @(posedge clk) begin
        int step, cen;
        cycles++;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_ph = 0; m_ovf = 0;
        end else begin
            step = (!half_rate || m_ph == 1) ? 1 : 0;
            m_ph = half_rate ? 1 - m_ph : 0;
            cen = (step == 1 && !wr_lo && !wr_hi) ? 1 : 0;
            m_ovf = (cen == 1 && m_lo == 255 && (!hi_en || m_hi == 255)) ? 1 : 0;
            if (wr_hi) m_hi = wr_data;
            else if (cen == 1 && hi_en && m_lo == 255) m_hi = (m_hi + 1) % 256;
            if (wr_lo) m_lo = wr_data;
            else if (cen == 1) m_lo = (m_lo + 1) % 256;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R2/R4/R5 lo", int'(lo_q), m_lo);
            chk("R3/R6/R7 hi", int'(hi_q), m_hi);
            chk("R8 ovf", int'(ovf), m_ovf);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(bit hi, logic [7:0] d);
        wr_data = d;
        if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
        cyc(1);
        wr_hi = 1'b0; wr_lo = 1'b0;
    endtask

    // R9: count clocks from load visibility until ovf
    task automatic period(string req, int exp_v);
        int n = 0;
        while (!ovf && n < exp_v + 10) begin
            cyc(1); n++;
        end
        chk(req, n, exp_v);
    endtask

    initial begin
        cyc(3);
        chk("R1 reset lo", int'(lo_q), 0);
        chk("R1 reset hi", int'(hi_q), 0);
        chk("R1 reset ovf", int'(ovf), 0);
        rst_n = 1'b1;
        // R4 free run, 8-bit
        cyc(10);
        // R2 load low, R9 8-bit period
        wr(0, 8'hF0);
        chk("R2 load", int'(lo_q), 240);
        period("R9 8-bit period", 16);
        chk("R8 ovf with zero", int'(lo_q), 0);
        cyc(1);
        chk("R8 ovf single", int'(ovf), 0);
        // R6 high byte frozen in 8-bit mode
        wr(1, 8'h5A);
        wr(0, 8'hFE);
        cyc(5);
        chk("R6 hi frozen", int'(hi_q), 90);
        // R7 16-bit carry and R9 16-bit period
        hi_en = 1'b1;
        wr(1, 8'hFF);
        wr(0, 8'h00);
        period("R9 16-bit period", 256);
        chk("R7 hi wrapped", int'(hi_q), 0);
        wr(0, 8'hFD);
        cyc(4);
        chk("R7 carry", int'(hi_q), 1);
        // R5 half rate, with writes on both phases
        half_rate = 1'b1;
        cyc(7);
        wr(0, 8'hF8);
        cyc(3);
        wr(1, 8'hFF);
        cyc(40);
        hi_en = 1'b0;
        wr(0, 8'hFC);
        cyc(12);
        half_rate = 1'b0;
        cyc(5);
        // simultaneous writes
        wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'h33;
        cyc(1);
        wr_lo = 1'b0; wr_hi = 1'b0;
        chk("R2/R3 both load", int'(hi_q), 51);
        // R1 reset mid-run
        rst_n = 1'b0;
        cyc(1);
        chk("R1 reset again", int'(lo_q) + int'(hi_q), 0);
        rst_n = 1'b1;
        cyc(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule